// File: doc/BRIEF.md
# Dual-Core Coherent Miss Classifier

This block tracks the tag state of two private, direct-mapped first-level caches that stay coherent through a snooped write-invalidate bus. It holds no data. A single request port accepts at most one access per cycle, and each access carries a core number, a load/store flag and an 8-bit byte address. The block updates the tag state of both caches, then labels the access with one of five outcomes: hit, compulsory miss, conflict miss, capacity miss or coherence miss.

Each cache has 8 rows of 8-byte blocks. The requesting core allocates on every miss, whether the access is a load or a store. A store from one core drops any matching valid line in the other core's cache and marks that row as snoop-invalidated. A miss that is neither first-touch nor caused by coherence is resolved by a per-core, fully-associative LRU shadow of the same capacity. If the block is still in that shadow, the miss is a conflict miss; if it is not, the miss is a capacity miss. Performance-analysis logic and coherence-protocol checking use the label stream that comes out.

Top module: `coh_miss_classifier`

## Requirements
- R1: After reset, res_valid_o is low and both caches hold no valid line, so the first access by either core is not a hit.
- R2: A byte address splits into block offset [2:0], row index [5:3] and tag [7:6]. An access that differs from the previously filled block only in bits [2:0] is a hit (code 0).
- R3: A miss on a block that the requesting core has never accessed since reset is a compulsory miss (code 1). This first-touch state is kept separately for each core.
- R4: A store by one core clears the other core's valid line when that line holds the same block. The next access by that other core to the block, at that row, is a coherence miss (code 4).
- R5: A store that hits in its own cache is reported as a hit (code 0), and it still invalidates the other core's copy.
- R6: Any other miss on a block that is among the requesting core's 8 most recently used distinct blocks is a conflict miss (code 2).
- R7: Any other miss on a block that is not among those 8 blocks is a capacity miss (code 3).
- R8: The result is registered. res_valid_o, res_core_o and res_kind_o appear one cycle after the request, and res_kind_o never exceeds 4.
- R9: A store miss allocates the line, so a later load by the same core to the same block is a hit.
- R10: A refill clears the snoop-invalidated mark on its row. If that block is evicted again later, its next miss is classified as conflict or capacity, not coherence.
- R11: A load does not disturb the other core's cache: a block the other core holds still hits there afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Access present this cycle |
| req_core_i | input | 1 | Requesting core (0 or 1) |
| req_store_i | input | 1 | 1 = store, 0 = load |
| req_addr_i | input | 8 | Byte address |
| res_valid_o | output | 1 | Result strobe, one cycle after the request |
| res_core_o | output | 1 | Core the result belongs to |
| res_kind_o | output | 3 | 0 hit, 1 compulsory, 2 conflict, 3 capacity, 4 coherence |

## Verification
An access is classified at the first rising edge after it is presented, so its label is due exactly one cycle later, and a request on the following cycle already sees the updated tag state. The bench changes the request on a falling edge and reads the result on the next falling edge, half a cycle after the edge that registered it. This lets back-to-back accesses check one label per cycle. Directed sequences pin the expected codes for coherence, store-hit invalidation, capacity and conflict, and a long pseudo-random stream is compared against a reference model kept in the bench.

// File: rtl/cmc_pkg.sv
package cmc_pkg;
  typedef enum logic [2:0] {
    KIND_HIT        = 3'd0,
    KIND_COMPULSORY = 3'd1,
    KIND_CONFLICT   = 3'd2,
    KIND_CAPACITY   = 3'd3,
    KIND_COHERENCE  = 3'd4
  } kind_e;
endpackage

// File: rtl/cmc_core_cache.sv
module cmc_core_cache #(
  parameter int BLK_W = 5,
  parameter int IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             snoop_inv_i,
  input  logic [BLK_W-1:0] blk_i,
  output logic             hit_o,
  output logic             seen_o,
  output logic             coh_o
);
  localparam int ROWS     = 1 << IDX_W;
  localparam int TAG_W    = BLK_W - IDX_W;
  localparam int NUM_BLKS = 1 << BLK_W;

  logic [ROWS-1:0]     valid_q;
  logic [ROWS-1:0]     inv_q;
  logic [TAG_W-1:0]    tag_q [ROWS];
  logic [NUM_BLKS-1:0] seen_q;

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic             tag_match;

  assign idx       = blk_i[IDX_W-1:0];
  assign tag       = blk_i[BLK_W-1:IDX_W];
  assign tag_match = (tag_q[idx] == tag);
  assign hit_o     = valid_q[idx] & tag_match;
  assign seen_o    = seen_q[blk_i];
  // invalidated line keeps its tag so a later miss can be traced to the snoop
  assign coh_o     = inv_q[idx] & ~valid_q[idx] & tag_match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      inv_q   <= '0;
      seen_q  <= '0;
      for (int i = 0; i < ROWS; i++) tag_q[i] <= '0;
    end else if (req_i) begin
      valid_q[idx]  <= 1'b1;
      inv_q[idx]    <= 1'b0;
      tag_q[idx]    <= tag;
      seen_q[blk_i] <= 1'b1;
    end else if (snoop_inv_i && hit_o) begin
      valid_q[idx] <= 1'b0;
      inv_q[idx]   <= 1'b1;
    end
  end

  AST_SNOOP_DROPS_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snoop_inv_i && !req_i && hit_o) |=> (!valid_q[$past(idx)] && inv_q[$past(idx)])); // R4

  AST_FILL_MARKS_SEEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (seen_q[$past(blk_i)] && valid_q[$past(idx)] && !inv_q[$past(idx)])); // R10
endmodule

// File: rtl/cmc_shadow_dir.sv
module cmc_shadow_dir #(
  parameter int BLK_W = 5,
  parameter int DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [BLK_W-1:0] blk_i,
  output logic             present_o
);
  // entry 0 is most recently used; entries shift down toward the LRU end
  logic [BLK_W-1:0] ent_q [DEPTH];
  logic [DEPTH-1:0] ent_v_q;
  logic [DEPTH-1:0] match;
  logic [DEPTH-1:0] shift_en;

  for (genvar g = 0; g < DEPTH; g++) begin : g_match
    assign match[g] = ent_v_q[g] && (ent_q[g] == blk_i);
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      shift_en[i] = ~|(match & ((DEPTH'(1) << i) - DEPTH'(1)));
  end

  assign present_o = |match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_v_q <= '0;
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else if (req_i) begin
      ent_q[0]   <= blk_i;
      ent_v_q[0] <= 1'b1;
      for (int i = 1; i < DEPTH; i++) begin
        if (shift_en[i]) begin
          ent_q[i]   <= ent_q[i-1];
          ent_v_q[i] <= ent_v_q[i-1];
        end
      end
    end
  end

  AST_SHADOW_UNIQUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match)); // R6

  AST_SHADOW_MRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (ent_v_q[0] && ent_q[0] == $past(blk_i))); // R7
endmodule

// File: rtl/cmc_classify.sv
module cmc_classify
  import cmc_pkg::*;
(
  input  logic  hit_i,
  input  logic  seen_i,
  input  logic  coh_i,
  input  logic  shadow_i,
  output kind_e kind_o
);
  always_comb begin
    if (hit_i)        kind_o = KIND_HIT;
    else if (!seen_i) kind_o = KIND_COMPULSORY;
    else if (coh_i)   kind_o = KIND_COHERENCE;
    else if (shadow_i) kind_o = KIND_CONFLICT;
    else              kind_o = KIND_CAPACITY;
  end
endmodule

// File: rtl/coh_miss_classifier.sv
module coh_miss_classifier
  import cmc_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int OFF_W        = 3,
  parameter int ROWS         = 8,
  parameter int SHADOW_DEPTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_core_i,
  input  logic              req_store_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              res_valid_o,
  output logic              res_core_o,
  output logic [2:0]        res_kind_o
);
  localparam int NUM_CORES = 2;
  localparam int IDX_W     = $clog2(ROWS);
  localparam int BLK_W     = ADDR_W - OFF_W;

  logic [BLK_W-1:0]     blk;
  logic [NUM_CORES-1:0] hit_w, seen_w, coh_w, shadow_w;
  logic                 sel_hit, sel_seen, sel_coh, sel_shadow;
  kind_e                kind;

  logic       res_valid_q, res_core_q, armed_q;
  logic [2:0] res_kind_q;

  assign blk = req_addr_i[ADDR_W-1:OFF_W];

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic own_req, snoop_inv;
    assign own_req   = req_valid_i && (req_core_i == 1'(c));
    assign snoop_inv = req_valid_i && req_store_i && (req_core_i != 1'(c));

    cmc_core_cache #(.BLK_W(BLK_W), .IDX_W(IDX_W)) u_cache (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .req_i      (own_req),
      .snoop_inv_i(snoop_inv),
      .blk_i      (blk),
      .hit_o      (hit_w[c]),
      .seen_o     (seen_w[c]),
      .coh_o      (coh_w[c])
    );

    cmc_shadow_dir #(.BLK_W(BLK_W), .DEPTH(SHADOW_DEPTH)) u_shadow (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .req_i    (own_req),
      .blk_i    (blk),
      .present_o(shadow_w[c])
    );
  end

  assign sel_hit    = hit_w[req_core_i];
  assign sel_seen   = seen_w[req_core_i];
  assign sel_coh    = coh_w[req_core_i];
  assign sel_shadow = shadow_w[req_core_i];

  cmc_classify u_classify (
    .hit_i   (sel_hit),
    .seen_i  (sel_seen),
    .coh_i   (sel_coh),
    .shadow_i(sel_shadow),
    .kind_o  (kind)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_q <= 1'b0;
      res_core_q  <= 1'b0;
      res_kind_q  <= 3'd0;
      armed_q     <= 1'b0;
    end else begin
      armed_q     <= 1'b1;
      res_valid_q <= req_valid_i;
      if (req_valid_i) begin
        res_core_q <= req_core_i;
        res_kind_q <= kind;
      end
    end
  end

  assign res_valid_o = res_valid_q;
  assign res_core_o  = res_core_q;
  assign res_kind_o  = res_kind_q;

  AST_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> (res_valid_o == $past(req_valid_i))); // R8

  AST_KIND_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (res_kind_o <= 3'd4)); // R8

  AST_REPEAT_HITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && req_valid_i && $past(req_valid_i) && req_core_i == $past(req_core_i)
     && blk == $past(blk)) |=> (res_kind_o == 3'd0)); // R2

  AST_HIT_NOT_COH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> !(sel_hit && sel_coh)); // R4
endmodule

// File: tb/coh_miss_classifier_tb.sv
module coh_miss_classifier_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_core = 1'b0;
  logic       req_store = 1'b0;
  logic [7:0] req_addr = '0;
  logic       res_valid, res_core;
  logic [2:0] res_kind;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  bit m_valid [2][8];
  int m_tag   [2][8];
  bit m_inv   [2][8];
  bit m_seen  [2][32];
  int m_sh    [2][8];

  always #2 clk = ~clk;

  coh_miss_classifier u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .req_valid_i(req_valid),
    .req_core_i (req_core),
    .req_store_i(req_store),
    .req_addr_i (req_addr),
    .res_valid_o(res_valid),
    .res_core_o (res_core),
    .res_kind_o (res_kind)
  );

  function automatic void model_reset();
    for (int c = 0; c < 2; c++) begin
      for (int i = 0; i < 8; i++) begin
        m_valid[c][i] = 1'b0; m_tag[c][i] = 0; m_inv[c][i] = 1'b0; m_sh[c][i] = -1;
      end
      for (int b = 0; b < 32; b++) m_seen[c][b] = 1'b0;
    end
  endfunction

  function automatic int model_access(int c, bit st, int addr);
    int blk = addr >> 3;
    int idx = blk & 7;
    int tg  = blk >> 3;
    int k;
    int p = 7;
    bit found = 1'b0;
    for (int i = 0; i < 8; i++)
      if (!found && m_sh[c][i] == blk) begin found = 1'b1; p = i; end
    if (m_valid[c][idx] && m_tag[c][idx] == tg) k = 0;
    else if (!m_seen[c][blk]) k = 1;
    else if (m_inv[c][idx] && m_tag[c][idx] == tg) k = 4;
    else k = found ? 2 : 3;
    m_valid[c][idx] = 1'b1; m_tag[c][idx] = tg; m_inv[c][idx] = 1'b0; m_seen[c][blk] = 1'b1;
    for (int i = p; i > 0; i--) m_sh[c][i] = m_sh[c][i-1];
    m_sh[c][0] = blk;
    if (st && m_valid[1-c][idx] && m_tag[1-c][idx] == tg) begin
      m_valid[1-c][idx] = 1'b0; m_inv[1-c][idx] = 1'b1;
    end
    return k;
  endfunction

  task automatic check(bit ok, string rq, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic apply_reset();
    req_valid = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    @(negedge clk);
  endtask

  // exp < 0: take the expected label from the model
  task automatic access(int c, bit st, int addr, int exp, string rq);
    int mk;
    int want;
    mk = model_access(c, st, addr);
    want = (exp >= 0) ? exp : mk;
    req_valid = 1'b1; req_core = c[0]; req_store = st; req_addr = addr[7:0];
    @(negedge clk);
    check(res_valid === 1'b1 && res_core === c[0], {rq, " strobe/core (R8)"},
          int'(res_valid), 1);
    check(res_kind === want[2:0], rq, int'(res_kind), want);
  endtask

  task automatic idle();
    req_valid = 1'b0;
    @(negedge clk);
    check(res_valid === 1'b0, "R8 idle strobe", int'(res_valid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    apply_reset();
    check(res_valid === 1'b0, "R1 reset strobe", int'(res_valid), 0);

    // two-core sequence
    access(0, 0, 63,  1, "R1 A ld 63 compulsory");
    access(0, 0, 57,  0, "R2 A ld 57 same block hit");
    access(1, 1, 63,  1, "R3 B st 63 per-core compulsory");
    access(0, 1, 63,  4, "R4 A st 63 coherence");
    access(1, 0, 102, 1, "R3 B ld 102 compulsory");
    access(0, 0, 121, 1, "R3 A ld 121 compulsory");
    access(0, 0, 57,  2, "R10 A ld 57 conflict after refill");
    idle();

    // write-allocate, load non-interference, store-hit invalidate
    apply_reset();
    access(0, 1, 16, 1, "R9 A st 16 miss");
    access(0, 0, 20, 0, "R9 A ld 20 allocated by store");
    access(1, 0, 16, 1, "R11 B ld 16");
    access(0, 0, 17, 0, "R11 A still holds block after B load");
    access(0, 1, 16, 0, "R5 A store hit");
    access(1, 0, 16, 4, "R5 B lost copy to store hit");
    idle();

    // capacity then conflict
    apply_reset();
    for (int b = 0; b < 9; b++) access(0, 0, b * 8, 1, "R3 A fill sweep");
    access(0, 0, 0,  3, "R7 A block 0 capacity");
    access(0, 0, 64, 2, "R6 A block 8 conflict");
    idle();

    // pseudo-random stream against the model
    apply_reset();
    begin
      int unsigned lcg = 32'h1234_5678;
      for (int n = 0; n < 1500; n++) begin
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        access(int'(lcg[20]), lcg[17:16] == 2'b00, int'(lcg[31:24]), -1,
               "R3/R4/R6/R7 stream");
      end
    end
    idle();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule